// File: doc/BRIEF.md
# Entropy Conditioning CRC Accumulator

This block turns three single-bit raw noise inputs into a 64-bit conditioned random word. Each input has its own enable. On every clock the enabled bits are combined by XOR into one bit, and that bit is folded into a 64-bit CRC register that runs over a fixed degree-64 generator. The register is presented as a read-only data word. Reads use a valid/ready handshake.

A small configuration interface holds three settings: a conditioning-mode flag, the three source enables and a wait count. With the mode flag set, an interlock counter holds ready low after each completed read until the programmed number of accumulation cycles has passed. The requester therefore never takes a word that has gathered less than the chosen amount of input. With the flag clear, reads are never stalled.

Top module: `entropy_crc_acc`

## Requirements
- R1: A synchronous reset (rst high) clears the CRC register to zero, sets the mode flag to 1, all three enables to 1 and the wait field to DEFAULT_WAIT, and loads the interlock counter with DEFAULT_WAIT. With the default of 4, rdReady is low in the first 4 cycles after reset and high in the fifth.
- R2: The input bit of each update is the XOR over i of srcBits[i] AND enable[i]. Enable bit i is cfgEnable[i], so bit 0 gates srcBits[0].
- R3: On every clock that is not in reset, the register becomes (crc << 1) XOR P when crc[63] XOR inBit is 1, and becomes crc << 1 otherwise.
- R4: P is the low 64 bits of the generator with terms at exponents 0, 1, 5, 7, 11, 12, 13, 15, 17, 21, 22, 25, 28, 32, 35, 37, 38, 39, 41, 42, 43, 46, 47, 48, 50, 51, 52, 56, 57, 61 and 64.
- R5: With all enables at 0 the input bit is a constant 0, and the register keeps stepping under R3.
- R6: rdData always equals the current CRC register. A read does not alter the register.
- R7: With the mode flag set, rdReady is low while the interlock counter is nonzero. A read that completes in cycle t (rdValid and rdReady both high) reloads the counter with the wait field W, so rdReady is next high in cycle t+W+1.
- R8: With the mode flag set and W = 0, rdReady stays high, so reads can complete in back-to-back cycles.
- R9: With the mode flag clear, rdReady is high in every cycle, whatever the state of the counter.
- R10: When a read completes in the same cycle as a configuration write, the reload uses the wait value held before that write. The new value governs only later reads.
- R11: A configuration write (cfgWe high) takes effect in the next cycle. Writing the mode flag to 0 while the counter is nonzero raises rdReady in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgMode | input | 1 | Conditioning-mode flag to write (1 enables the interlock) |
| cfgEnable | input | 3 | Per-source enables to write |
| cfgWait | input | WAIT_W | Wait count to write, in cycles |
| srcBits | input | 3 | Raw entropy bits, one per source |
| rdValid | input | 1 | Read request |
| rdReady | output | 1 | Read may complete this cycle |
| rdData | output | 64 | Current CRC register value |

## Verification
Two functions can fall in one cycle: the completion of a read, which reloads the interlock counter, and a configuration write that changes the wait field. The bench provokes this by raising rdValid and cfgWe on the same edge while rdReady is high. It judges the result by the gap until rdReady returns, which must follow the old wait value, and by the gap after the next read, which must follow the new one. A second overlap comes from clearing the mode flag while the counter is still counting down; the bench expects ready to rise on the very next cycle.

// File: rtl/erc_pkg.sv
package erc_pkg;
  localparam int CRC_W = 64;
  localparam int SRC_N = 3;

  // Low 64 bits of the degree-64 generator; the x^64 term is implicit.
  localparam logic [CRC_W-1:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic             clear;
    logic [SRC_N-1:0] srcMask;
  } dp_ctl_t;
endpackage

// File: rtl/erc_datapath.sv
module erc_datapath
  import erc_pkg::*;
(
  input  logic             clk,
  input  dp_ctl_t          dpCtl,
  input  logic [SRC_N-1:0] srcBits,
  output logic [CRC_W-1:0] crcOut
);
  logic [SRC_N-1:0] gatedBits;
  logic             inBit;
  logic             feedBack;
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcNext;

  // Gate each source by its enable.
  for (genvar i = 0; i < SRC_N; i++) begin : g_gate
    assign gatedBits[i] = srcBits[i] & dpCtl.srcMask[i];
  end

  assign inBit    = ^gatedBits;
  assign feedBack = crcReg[CRC_W-1] ^ inBit;

  always_comb begin
    crcNext = {crcReg[CRC_W-2:0], 1'b0};
    if (feedBack) crcNext = crcNext ^ CRC_POLY;
  end

  always_ff @(posedge clk) begin
    if (dpCtl.clear) crcReg <= '0;
    else             crcReg <= crcNext;
  end

  assign crcOut = crcReg;

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (dpCtl.clear)
    (crcReg == '0 && dpCtl.srcMask == '0) |=> (crcReg == '0)) else $error("zero hold"); // R5

  AST_PLAIN_SHIFT: assert property (@(posedge clk) disable iff (dpCtl.clear)
    (!crcReg[CRC_W-1] && gatedBits == '0) |=> (crcReg == {$past(crcReg[CRC_W-2:0]), 1'b0})) else $error("plain shift"); // R3

  AST_POLY_FOLD: assert property (@(posedge clk) disable iff (dpCtl.clear)
    (crcReg[CRC_W-1] && gatedBits == '0) |=> (crcReg == ({$past(crcReg[CRC_W-2:0]), 1'b0} ^ CRC_POLY))) else $error("poly fold"); // R4
endmodule

// File: rtl/erc_ctrl.sv
module erc_ctrl
  import erc_pkg::*;
#(
  parameter int WAIT_W       = 8,
  parameter int DEFAULT_WAIT = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic              cfgMode,
  input  logic [SRC_N-1:0]  cfgEnable,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              rdValid,
  output logic              rdReady,
  output dp_ctl_t           dpCtl
);
  localparam logic [WAIT_W-1:0] RST_WAIT = WAIT_W'(DEFAULT_WAIT);

  logic              modeReg;
  logic [SRC_N-1:0]  enableReg;
  logic [WAIT_W-1:0] waitReg;
  logic [WAIT_W-1:0] lockCnt;
  logic              readDone;

  // Configuration holding registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg   <= 1'b1;
      enableReg <= '1;
      waitReg   <= RST_WAIT;
    end else if (cfgWe) begin
      modeReg   <= cfgMode;
      enableReg <= cfgEnable;
      waitReg   <= cfgWait;
    end
  end

  assign rdReady  = !modeReg || (lockCnt == '0);
  assign readDone = rdValid && rdReady;

  // Interlock counter: reload on a completed read, else count down to zero.
  always_ff @(posedge clk) begin
    if (rst)                 lockCnt <= RST_WAIT;
    else if (readDone)       lockCnt <= waitReg;
    else if (lockCnt != '0)  lockCnt <= lockCnt - 1'b1;
  end

  always_comb begin
    dpCtl.clear   = rst;
    dpCtl.srcMask = enableReg;
  end

  AST_NOMODE_READY: assert property (@(posedge clk) disable iff (rst)
    !modeReg |-> rdReady) else $error("ready low without mode"); // R9

  AST_STALL: assert property (@(posedge clk) disable iff (rst)
    (modeReg && lockCnt != '0) |-> !rdReady) else $error("ready during lock"); // R7

  AST_RELOAD_OLD_WAIT: assert property (@(posedge clk) disable iff (rst)
    readDone |=> (lockCnt == $past(waitReg))) else $error("reload value"); // R10

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!readDone && lockCnt != '0) |=> (lockCnt == $past(lockCnt) - 1'b1)) else $error("count down"); // R7
endmodule

// File: rtl/entropy_crc_acc.sv
module entropy_crc_acc
  import erc_pkg::*;
#(
  parameter int WAIT_W       = 8,
  parameter int DEFAULT_WAIT = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic              cfgMode,
  input  logic [2:0]        cfgEnable,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic [2:0]        srcBits,
  input  logic              rdValid,
  output logic              rdReady,
  output logic [63:0]       rdData
);
  dp_ctl_t dpCtl;

  erc_ctrl #(
    .WAIT_W      (WAIT_W),
    .DEFAULT_WAIT(DEFAULT_WAIT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgMode  (cfgMode),
    .cfgEnable(cfgEnable),
    .cfgWait  (cfgWait),
    .rdValid  (rdValid),
    .rdReady  (rdReady),
    .dpCtl    (dpCtl)
  );

  erc_datapath u_dp (
    .clk    (clk),
    .dpCtl  (dpCtl),
    .srcBits(srcBits),
    .crcOut (rdData)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rdData == 64'd0)) else $error("reset clear"); // R1

  AST_DATA_HELD_BY_READ: assert property (@(posedge clk) disable iff (rst)
    (rdValid && rdReady && !rdData[63] && dpCtl.srcMask == '0) |=> (rdData == {$past(rdData[62:0]), 1'b0})) else $error("read altered data"); // R6
endmodule

// File: tb/entropy_crc_acc_bench.sv
module entropy_crc_acc_bench;
  localparam int WAIT_W = 8;
  localparam int DEF_WAIT = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfgWe;
  logic              cfgMode;
  logic [2:0]        cfgEnable;
  logic [WAIT_W-1:0] cfgWait;
  logic [2:0]        srcBits;
  logic              rdValid;
  logic              rdReady;
  logic [63:0]       rdData;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int cyc = 0;
  string curTag = "R3";
  bit dataCheckOn = 0;

  logic [63:0] polyB;
  logic [63:0] modelCrc;
  logic [2:0]  modelEn;

  always #5 clk = ~clk;

  entropy_crc_acc #(.WAIT_W(WAIT_W), .DEFAULT_WAIT(DEF_WAIT)) u_entropy_crc_acc (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgMode(cfgMode), .cfgEnable(cfgEnable),
    .cfgWait(cfgWait), .srcBits(srcBits), .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData)
  );

  function automatic logic [63:0] buildPoly();
    int exps[30] = '{0, 1, 5, 7, 11, 12, 13, 15, 17, 21, 22, 25, 28, 32, 35,
                     37, 38, 39, 41, 42, 43, 46, 47, 48, 50, 51, 52, 56, 57, 61};
    logic [63:0] p = '0;
    foreach (exps[k]) p[exps[k]] = 1'b1;
    return p;
  endfunction

  function automatic logic [63:0] crcStep(logic [63:0] c, logic b);
    logic fb = c[63] ^ b;
    logic [63:0] n = c << 1;
    if (fb) n = n ^ polyB;
    return n;
  endfunction

  initial polyB = buildPoly();

  // Reference model of the register (R2, R3, R4).
  always @(posedge clk) begin
    if (rst) begin
      modelCrc <= '0;
      modelEn  <= 3'b111;
    end else begin
      modelCrc <= crcStep(modelCrc, ^(srcBits & modelEn));
      if (cfgWe) modelEn <= cfgEnable;
    end
  end

  // Source stimulus pattern.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    srcBits <= 3'(cyc * 5) ^ 3'(cyc >> 2) ^ 3'(cyc >> 5);
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous data compare (R6: reads never disturb the register).
  always @(negedge clk) begin
    if (dataCheckOn && !rst) check(rdData === modelCrc, curTag, rdData, modelCrc);
  end

  task automatic cfgSet(logic m, logic [2:0] en, int w);
    cfgWe = 1; cfgMode = m; cfgEnable = en; cfgWait = WAIT_W'(w);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 300 && !rdReady; i++) @(negedge clk);
  endtask

  task automatic measureGap(int expGap, string tag);
    int k;
    waitReady();
    rdValid = 1;
    @(negedge clk);
    rdValid = 0;
    k = 1;
    while (!rdReady && k < 300) begin @(negedge clk); k++; end
    check(k == expGap, tag, 64'(k), 64'(expGap));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int k;
    rst = 1; cfgWe = 0; cfgMode = 1; cfgEnable = 3'b111; cfgWait = '0; rdValid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state and ready timing.
    check(rdData == 64'd0, "R1", rdData, 64'd0);
    for (int i = 0; i <= DEF_WAIT; i++) begin
      check(rdReady == (i >= DEF_WAIT), "R1", 64'(rdReady), 64'(i >= DEF_WAIT));
      @(negedge clk);
    end
    dataCheckOn = 1;

    // R2/R3/R4: sweep every enable mask, with reads sprinkled in (R6).
    for (int m = 0; m < 8; m++) begin
      curTag = (m == 0) ? "R5" : "R2";
      cfgSet(1'b0, 3'(m), 0);
      for (int j = 0; j < 24; j++) begin
        rdValid = (j % 3 == 0);
        @(negedge clk);
      end
      rdValid = 0;
    end
    curTag = "R3";

    // R5: all disabled from a nonzero state keeps stepping.
    cfgSet(1'b0, 3'b111, 0);
    repeat (10) @(negedge clk);
    curTag = "R5";
    cfgSet(1'b0, 3'b000, 0);
    repeat (70) @(negedge clk);
    curTag = "R6";
    cfgSet(1'b1, 3'b101, 0);

    // R7: interlock gap for a sweep of wait values.
    for (int w = 0; w <= 6; w++) begin
      cfgSet(1'b1, 3'b111, w);
      measureGap(w + 1, "R7");
      measureGap(w + 1, "R7");
    end

    // R8: W = 0 allows back-to-back reads.
    cfgSet(1'b1, 3'b011, 0);
    waitReady();
    rdValid = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(rdReady == 1'b1, "R8", 64'(rdReady), 64'd1);
    end
    rdValid = 0;

    // R9: mode clear never stalls, even with a large wait.
    cfgSet(1'b0, 3'b111, 9);
    rdValid = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(rdReady == 1'b1, "R9", 64'(rdReady), 64'd1);
    end
    rdValid = 0;

    // R10: read and config write in the same cycle.
    cfgSet(1'b1, 3'b111, 2);
    measureGap(3, "R10");
    waitReady();
    rdValid = 1; cfgWe = 1; cfgMode = 1; cfgEnable = 3'b110; cfgWait = WAIT_W'(5);
    @(negedge clk);
    rdValid = 0; cfgWe = 0;
    k = 1;
    while (!rdReady && k < 300) begin @(negedge clk); k++; end
    check(k == 3, "R10", 64'(k), 64'd3);
    measureGap(6, "R10");

    // R11: clearing mode mid-countdown releases ready next cycle.
    cfgSet(1'b1, 3'b111, 8);
    waitReady();
    rdValid = 1;
    @(negedge clk);
    rdValid = 0;
    @(negedge clk);
    check(rdReady == 1'b0, "R11", 64'(rdReady), 64'd0);
    cfgWe = 1; cfgMode = 0; cfgEnable = 3'b111; cfgWait = WAIT_W'(8);
    check(rdReady == 1'b0, "R11", 64'(rdReady), 64'd0);
    @(negedge clk);
    cfgWe = 0;
    check(rdReady == 1'b1, "R11", 64'(rdReady), 64'd1);

    // R1: reset mid-run clears the register.
    rst = 1;
    dataCheckOn = 0;
    @(negedge clk);
    rst = 0;
    check(rdData == 64'd0, "R1", rdData, 64'd0);
    check(rdReady == 1'b0, "R1", 64'(rdReady), 64'd0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule